// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block is the device side of the three-wire serial port of a delta-sigma converter. It moves through three phases. In the conversion phase it waits for a result from the conversion engine. In the sleep phase it holds a finished result. In the data phase it shifts that result out. An active-low select, `cs_ni`, gates the data pin. Outside the data phase, the same pin reports whether a result is ready, so a host can poll by lowering select. It can then read the word in the same select window.

The serial clock has two directions. If the clock pin is high when it is sampled, the block generates the clock from its system clock and enables a weak pull-up. If the pin is low, the host supplies the clock. The pin is sampled on the first clock after reset and again on every falling edge of select.

The conversion engine is outside this block. A stub pulses `conv_done_i` and presents a signed raw value on `result_i`. The block maps that value into a 24-bit code that keeps overrange and underrange apart from every in-range code. When a transfer finishes, or when select rises during it, a new conversion starts.

Top module: `adc_serial_if`

## Requirements
- R1: `sdo_oe_o` is high exactly while `cs_ni` is low; with select high the data pin is released.
- R2: After reset the block is in the conversion phase. The clock mode is taken from `sck_i` on the first clock after reset: high selects internal, low selects external.
- R3: Outside the data phase, `sdo_o` is 1 while a conversion is in progress and 0 while a result waits in the sleep phase.
- R4: A `conv_done_i` pulse in the conversion phase loads the result and moves the block to sleep. The block stays in sleep while `cs_ni` is high. A `conv_done_i` pulse outside the conversion phase changes nothing, and the stored word is kept.
- R5: The output code is formed from the signed raw value r as follows. If r ≥ 2^22, the code is 0xFFFFFF. If r < −2^22, the code is 0x000000. If 0 ≤ r < 2^22, the code is bits 23:22 = 2'b10 followed by r[21:0]. If −2^22 ≤ r < 0, the code is bits 23:22 = 2'b01 followed by r[21:0].
- R6: With `cs_ni` low in sleep, the data phase begins on the next clock. The 24-bit code is sent MSB first. Each new bit appears on a falling serial clock edge and stays stable until the next one, so the host samples on rising edges.
- R7: After the 24th falling serial clock edge the block returns to the conversion phase, and `sdo_o` shows 1 while select stays low.
- R8: A rising edge of `cs_ni` during the data phase ends the transfer at once and returns the block to the conversion phase. This still holds when it coincides with the last falling clock edge.
- R9: A falling edge of `cs_ni` loads the clock mode from `sck_i`. A falling edge that meets a ready result starts the transfer in the newly loaded mode.
- R10: In internal mode, `sck_o` is low on entry to the data phase and toggles every `HALF_DIV` system clocks. It is held low outside the data phase. `sck_oe_o` is high only in the data phase. `sck_pu_o` is high whenever internal mode is selected.
- R11: In external mode, `sck_oe_o` stays low and each falling edge of `sck_i` advances the output by one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock pin level (host clock in external mode, mode strap) |
| result_i | input | RAW_W | Signed raw conversion value from the engine stub |
| conv_done_i | input | 1 | One-cycle strobe: conversion finished |
| sdo_o | output | 1 | Serial data or ready status |
| sdo_oe_o | output | 1 | Output enable for the data pin |
| sck_o | output | 1 | Generated serial clock in internal mode |
| sck_oe_o | output | 1 | Output enable for the serial clock pin |
| sck_pu_o | output | 1 | Weak pull-up enable on the serial clock pin |

## Verification
Two pairs of events can fall on the same clock edge. In the first, the conversion-done strobe arrives while select is already low, so the block passes through a one-cycle sleep into the transfer. In the second, select rises on the same edge as the final falling host clock edge, so the abort and normal completion must agree on the next phase. The bench provokes both with edge-aligned stimulus. A behavioural reference model, updated on every clock, judges all five outputs. A directed check on the status level that follows confirms the new conversion phase.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_sif_fmt.sv
module adc_sif_fmt #(
  parameter int RAW_W  = 24,
  parameter int WORD_W = 24
) (
  input  logic signed [RAW_W-1:0] raw_i,
  output logic [WORD_W-1:0]       word_o
);
  localparam int MAG_W = WORD_W - 2;
  localparam logic signed [RAW_W-1:0] POS_LIM =
    {{(RAW_W-MAG_W-1){1'b0}}, 1'b1, {MAG_W{1'b0}}};
  localparam logic signed [RAW_W-1:0] NEG_LIM = -POS_LIM;

  always_comb begin
    if (raw_i >= POS_LIM)      word_o = {2'b11, {MAG_W{1'b1}}};
    else if (raw_i < NEG_LIM)  word_o = {2'b00, {MAG_W{1'b0}}};
    else if (raw_i[RAW_W-1])   word_o = {2'b01, raw_i[MAG_W-1:0]};
    else                       word_o = {2'b10, raw_i[MAG_W-1:0]};
  end

  // R5: in-range header never collides with the saturation codes
  always_comb begin
    if (!$isunknown(raw_i) && raw_i < POS_LIM && raw_i >= NEG_LIM)
      a_r5_inrange_hdr: assert (word_o[WORD_W-1] != word_o[WORD_W-2]);
  end
endmodule

// File: rtl/adc_sif_sckgen.sv
module adc_sif_sckgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (cnt_q == CNT_TOP) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o  = sck_q & run_i;
  assign fall_o = run_i & sck_q & (cnt_q == CNT_TOP);

  // R10: a new run always begins with the clock low
  a_r10_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_q);
endmodule

// File: rtl/adc_sif_shifter.sv
module adc_sif_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int BCNT_W = $clog2(WORD_W);
  localparam logic [BCNT_W-1:0] BCNT_TOP = BCNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [BCNT_W-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
    end else if (load_i) begin
      shreg_q <= word_i;
      bcnt_q  <= '0;
    end else if (shift_i) begin
      shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      bcnt_q  <= (bcnt_q == BCNT_TOP) ? '0 : bcnt_q + 1'b1;
    end
  end

  assign msb_o  = shreg_q[WORD_W-1];
  assign last_o = shift_i & (bcnt_q == BCNT_TOP);

  // R6: data holds between clock falls
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(shreg_q));
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_sif_pkg::*;
#(
  parameter int RAW_W    = 24,
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic [RAW_W-1:0] result_i,
  input  logic             conv_done_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             sck_pu_o
);
  phase_e state_q, state_d;
  logic   cs_q, sck_q, init_q, int_mode_q;
  logic   cs_rise, cs_fall, ext_fall, int_fall, shift_w, load_w, last_w, msb_w, run_int;
  logic [WORD_W-1:0] code_w;

  adc_sif_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
    .raw_i  (result_i),
    .word_o (code_w)
  );

  assign run_int = (state_q == ST_DOUT) & int_mode_q;

  adc_sif_sckgen #(.HALF_DIV(HALF_DIV)) u_sckgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_int),
    .sck_o  (sck_o),
    .fall_o (int_fall)
  );

  assign cs_rise  = ~cs_q & cs_ni;
  assign cs_fall  = cs_q & ~cs_ni;
  assign ext_fall = sck_q & ~sck_i;
  assign shift_w  = (state_q == ST_DOUT) & (int_mode_q ? int_fall : ext_fall);
  assign load_w   = (state_q == ST_CONV) & conv_done_i;

  adc_sif_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .word_i  (code_w),
    .shift_i (shift_w),
    .msb_o   (msb_w),
    .last_o  (last_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CONV:  if (conv_done_i) state_d = ST_SLEEP;
      ST_SLEEP: if (!cs_ni) state_d = ST_DOUT;
      ST_DOUT:  if (cs_rise || last_w) state_d = ST_CONV;
      default:  state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CONV;
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      init_q     <= 1'b1;
      int_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_ni;
      sck_q   <= sck_i;
      init_q  <= 1'b0;
      if (init_q || cs_fall) int_mode_q <= sck_i;
    end
  end

  assign sdo_o    = (state_q == ST_DOUT) ? msb_w : (state_q == ST_CONV);
  assign sdo_oe_o = ~cs_ni;
  assign sck_oe_o = run_int;
  assign sck_pu_o = int_mode_q;

  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOUT && cs_rise) |=> state_q == ST_CONV);

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOUT && last_w) |=> state_q == ST_CONV);

  a_r4_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && cs_ni) |=> state_q == ST_SLEEP);

  a_r9_mode_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && cs_fall) |=> int_mode_q == $past(sck_i));
endmodule

// File: tb/adc_serial_if_tb_top.sv
`timescale 1ns/100ps
module adc_serial_if_tb_top;
  localparam int HALF = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sck_i = 1'b1;
  logic [23:0] result_i = '0;
  logic        conv_done_i = 1'b0;
  logic        sdo_o, sdo_oe_o, sck_o, sck_oe_o, sck_pu_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_serial_if #(.RAW_W(24), .WORD_W(24), .HALF_DIV(HALF)) dut_i (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .result_i, .conv_done_i,
    .sdo_o, .sdo_oe_o, .sck_o, .sck_oe_o, .sck_pu_o
  );

  function automatic logic [23:0] fmt(int v);
    if (v >= (1 << 22)) return 24'hFFFFFF;
    if (v < -(1 << 22)) return 24'h000000;
    if (v < 0) return {2'b01, v[21:0]};
    return {2'b10, v[21:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 conv, 1 sleep, 2 data
  int          m_st = 0, m_cnt = 0, m_div = 0;
  logic [23:0] m_w = '0;
  logic        m_mode = 0, m_init = 1, m_csq = 1, m_sckq = 0, m_sck = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_div = 0; m_w = '0;
      m_mode = 0; m_init = 1; m_csq = 1; m_sckq = 0; m_sck = 0;
    end else begin
      bit fall, rise_cs, fall_cs;
      rise_cs = !m_csq && cs_ni;
      fall_cs = m_csq && !cs_ni;
      fall = 0;
      if (m_st == 2 && m_mode) begin
        if (m_div == HALF - 1) begin fall = m_sck; m_sck = !m_sck; m_div = 0; end
        else m_div++;
      end else begin
        m_sck = 0; m_div = 0;
      end
      if (m_st == 2 && !m_mode) fall = m_sckq && !sck_i;
      case (m_st)
        0: if (conv_done_i) begin m_w = fmt(int'($signed(result_i))); m_cnt = 0; m_st = 1; end
        1: if (!cs_ni) m_st = 2;
        default: begin
          if (fall) begin m_w = m_w << 1; m_cnt++; end
          if (rise_cs || (fall && m_cnt == 24)) begin m_st = 0; m_cnt = 0; end
        end
      endcase
      if (m_init || fall_cs) m_mode = sck_i;
      m_init = 0;
      m_csq = cs_ni;
      m_sckq = sck_i;
    end
  end

  always @(negedge clk_i) begin
    if (mon_en) begin
      #1;
      chk("R1 sdo_oe", sdo_oe_o, !cs_ni);
      if (m_st == 2) chk("R6 sdo data", sdo_o, m_w[23]);
      else           chk("R3 sdo status", sdo_o, (m_st == 0));
      chk("R10 sck_o", sck_o, m_sck && m_st == 2 && m_mode);
      chk("R11 sck_oe", sck_oe_o, (m_st == 2) && m_mode);
      chk("R10 pullup", sck_pu_o, m_mode);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_conv(int v);
    @(negedge clk_i);
    result_i = 24'(v);
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
  endtask

  task automatic ext_read(output logic [23:0] w, input bit abort_last);
    w = '0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i);
      sck_i = 1'b1;
      #1 w = {w[22:0], sdo_o};
      if (i == 0) chk("R11 no clock drive", sck_oe_o, 1'b0);
      @(negedge clk_i);
      sck_i = 1'b0;
      if (abort_last && i == 23) cs_ni = 1'b1;
    end
  endtask

  task automatic int_read(output logic [23:0] w);
    w = '0;
    for (int i = 0; i < 24; i++) begin
      @(posedge sck_o);
      #1 w = {w[22:0], sdo_o};
    end
  endtask

  task automatic ext_case(int v);
    logic [23:0] w;
    sck_i = 1'b0;
    do_conv(v);
    tick(1);
    cs_ni = 1'b0;
    tick(1);
    ext_read(w, 1'b0);
    chk("R5 code", w, fmt(v));
    tick(1);
    #1 chk("R7 status after last bit", sdo_o, 1'b1);
    cs_ni = 1'b1;
  endtask

  initial begin
    logic [23:0] w;
    tick(3);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    tick(2);
    #1 chk("R2 internal mode from reset strap", sck_pu_o, 1'b1);
    chk("R1 released", sdo_oe_o, 1'b0);
    cs_ni = 1'b0;
    tick(1);
    #1 chk("R2 conversion after reset", sdo_o, 1'b1);
    cs_ni = 1'b1;

    // internal clock transfer; a strobe during sleep is ignored
    do_conv(1234);
    tick(2);
    @(negedge clk_i); result_i = 24'(999); conv_done_i = 1'b1;
    @(negedge clk_i); conv_done_i = 1'b0;
    tick(3);
    cs_ni = 1'b0;
    #1 chk("R3 ready status", sdo_o, 1'b0);
    int_read(w);
    chk("R4 first result kept", w, fmt(1234));
    tick(2 * HALF + 2);
    #1 chk("R7 back to conversion", sdo_o, 1'b1);
    cs_ni = 1'b1;

    // external clock transfers across the code map
    ext_case(-5);
    ext_case((1 << 22) - 1);
    ext_case(-(1 << 22));
    ext_case((1 << 22));
    ext_case(-(1 << 22) - 1);
    ext_case(0);
    tick(2);
    #1 chk("R9 external mode latched", sck_pu_o, 1'b0);

    // abort in internal mode
    sck_i = 1'b1;
    do_conv(77);
    tick(1);
    cs_ni = 1'b0;
    tick(1);
    #1 chk("R9 internal mode latched", sck_pu_o, 1'b1);
    tick(20);
    cs_ni = 1'b1;
    tick(1);
    cs_ni = 1'b0;
    #1 chk("R8 aborted to conversion", sdo_o, 1'b1);
    chk("R8 clock released", sck_oe_o, 1'b0);
    cs_ni = 1'b1;

    // strobe while select already low, then abort on the last fall
    tick(1);
    sck_i = 1'b0;
    cs_ni = 1'b0;
    tick(1);
    do_conv(4321);
    ext_read(w, 1'b1);
    chk("R6 word with select held low", w, fmt(4321));
    tick(1);
    cs_ni = 1'b0;
    #1 chk("R8 abort on last fall", sdo_o, 1'b1);
    cs_ni = 1'b1;
    tick(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule